// File: doc/BRIEF.md
# Playback DMA Slave Channel Register Bank

This block is the byte-wide register bank of a single playback channel that behaves like one channel of a classic four-channel DMA controller. It keeps a 32-bit transfer address and a 24-bit byte count, each as a base copy and a current copy. It also holds a control byte and a read-only status byte. Software reaches the same registers through two relocatable 16-byte I/O windows: one for the distributed DMA master and one for the audio driver or a debug tool. The fixed ISA-era DMA ports also reach them. A byte pointer steers the shared low/high ports.

A transfer engine outside the block pulses a step input once per byte moved. While the channel is enabled, each pulse advances the current address and counts the current byte count down. When the count steps past zero, the channel sets its terminal-count flag and reloads both current values from the base copies. The status byte is formatted differently for each window. A read through the fixed status port clears the terminal-count flag.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register, the byte pointer and the terminal-count flag are zero, and `io_ack` and `io_rdata` are low.
- R2: An access hits the slave window when `io_addr[15:4]` equals `slave_base[15:4]` and `io_addr[3:0]` is 0..8, and hits the audio window in the same way with `audio_base`. The slave window takes priority over the audio window, and the audio window over the fixed ports. Both windows reach the same nine registers: offsets 0..3 are address bytes 0..3 (LSB first), offsets 4..6 are count bytes 0..2, offset 7 is the control byte and offset 8 is status.
- R3: A write to an address or count byte loads both its base and current copies, and a read returns the current copy.
- R4: Fixed ports 0x0000/0x0002 reach address byte 0 when the byte pointer is 0 and byte 1 when it is 1. Ports 0x0001/0x0003 reach count byte 0 or 1 in the same way. Ports 0x0087/0x0083 reach address byte 2, and port 0x0008 is status. Each accepted access to 0x0000..0x0003 toggles the pointer.
- R5: A read of a fixed port while `snoop_en` is low, or of an undecoded address, returns `io_ack`=0 and `io_rdata`=0x00, and leaves the byte pointer unchanged. Writes to fixed ports are accepted regardless of `snoop_en`.
- R6: Read data and `io_ack` appear in the cycle after `io_rd` is sampled, and `io_rdata` is 0x00 whenever `io_ack` is low.
- R7: A step pulse with control bit 0 set and no register write in the same cycle increments the current address by 1 and decrements the current count by 1. Otherwise the pulse has no effect, and a simultaneous write wins.
- R8: A step taken while the current count is 0 reloads the current address and count from their base copies and sets `tc_flag`.
- R9: Status through the slave window is {3'b0, run, 3'b0, tc}. Through the audio window it is {run, 5'b0, byte pointer, tc}. Through port 0x0008 it has tc at bit CHAN and run at bit CHAN+4, where run is control bit 0.
- R10: A read of port 0x0008 clears `tc_flag`, unless a terminal step sets it in the same cycle. Status reads through either window leave it set.
- R11: Writes to the status offset change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| slave_base | input | 16 | Slave window base, bits 15:4 used |
| audio_base | input | 16 | Audio window base, bits 15:4 used |
| snoop_en | input | 1 | Enables read responses on fixed ports |
| xfer_step | input | 1 | One pulse per transferred byte |
| io_ack | output | 1 | Read response, registered |
| io_rdata | output | 8 | Read data, registered |
| tc_flag | output | 1 | Terminal-count flag |

## Verification
Read results are registered, so `io_ack` and `io_rdata` for a read strobe sampled at edge N are due between edges N+1 and N+2. The bench tags each expected read with that cycle number and pops it only when the cycle count has reached it. Writes, steps and flag clears act at the same edge that samples them. The bench therefore drives them one cycle ahead and reads the result back through a window, or samples `tc_flag` on the next falling edge. The fixed-port checks follow the byte pointer across every accepted access, and one read is refused to show that a refused read leaves the pointer unchanged.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
    localparam int IO_AW      = 16;
    localparam int DATA_W     = 8;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = 24;
    localparam int ADDR_BYTES = ADDR_W / DATA_W;
    localparam int CNT_BYTES  = CNT_W / DATA_W;
    localparam int IDX_W      = 4;
    localparam int IDX_MISC   = ADDR_BYTES + CNT_BYTES;
    localparam int IDX_STAT   = IDX_MISC + 1;
    localparam int CAT_W      = ADDR_W + CNT_W;

    localparam logic [IO_AW-1:0] P_ADDR_A = 16'h0000;
    localparam logic [IO_AW-1:0] P_ADDR_B = 16'h0002;
    localparam logic [IO_AW-1:0] P_CNT_A  = 16'h0001;
    localparam logic [IO_AW-1:0] P_CNT_B  = 16'h0003;
    localparam logic [IO_AW-1:0] P_PAGE_A = 16'h0087;
    localparam logic [IO_AW-1:0] P_PAGE_B = 16'h0083;
    localparam logic [IO_AW-1:0] P_STAT   = 16'h0008;

    typedef enum logic [1:0] {
        WIN_NONE, WIN_SLAVE, WIN_AUDIO, WIN_LEGACY
    } win_e;

    typedef struct packed {
        logic             hit;
        win_e             win;
        logic [IDX_W-1:0] idx;
        logic             ptr_port;
    } dec_t;

    function automatic logic [DATA_W-1:0] status_byte(
        input win_e win, input logic tc, input logic run,
        input logic ptr, input int chan);
        logic [DATA_W-1:0] s;
        s = '0;
        case (win)
            WIN_SLAVE:  begin s[0] = tc; s[4] = run; end
            WIN_AUDIO:  begin s[0] = tc; s[1] = ptr; s[7] = run; end
            WIN_LEGACY: begin s[chan] = tc; s[chan+4] = run; end
            default:    s = '0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/dma_io_decode.sv
module dma_io_decode
    import dma_regs_pkg::*;
(
    input  logic [IO_AW-1:0] addr,
    input  logic [IO_AW-1:0] slave_base,
    input  logic [IO_AW-1:0] audio_base,
    input  logic             byte_ptr,
    output dec_t             dec
);
    localparam int OFS_W = 4;

    logic slave_hit, audio_hit;

    assign slave_hit = (addr[IO_AW-1:OFS_W] == slave_base[IO_AW-1:OFS_W])
                       && (addr[OFS_W-1:0] <= OFS_W'(IDX_STAT));
    assign audio_hit = (addr[IO_AW-1:OFS_W] == audio_base[IO_AW-1:OFS_W])
                       && (addr[OFS_W-1:0] <= OFS_W'(IDX_STAT));

    always_comb begin
        dec = '{hit: 1'b0, win: WIN_NONE, idx: '0, ptr_port: 1'b0};
        if (slave_hit) begin
            dec.hit = 1'b1;
            dec.win = WIN_SLAVE;
            dec.idx = IDX_W'(addr[OFS_W-1:0]);
        end else if (audio_hit) begin
            dec.hit = 1'b1;
            dec.win = WIN_AUDIO;
            dec.idx = IDX_W'(addr[OFS_W-1:0]);
        end else begin
            dec.win = WIN_LEGACY;
            dec.hit = 1'b1;
            case (addr)
                P_ADDR_A, P_ADDR_B: begin
                    dec.idx      = byte_ptr ? IDX_W'(1) : IDX_W'(0);
                    dec.ptr_port = 1'b1;
                end
                P_CNT_A, P_CNT_B: begin
                    dec.idx      = byte_ptr ? IDX_W'(ADDR_BYTES + 1) : IDX_W'(ADDR_BYTES);
                    dec.ptr_port = 1'b1;
                end
                P_PAGE_A, P_PAGE_B: dec.idx = IDX_W'(2);
                P_STAT:             dec.idx = IDX_W'(IDX_STAT);
                default: begin
                    dec.hit = 1'b0;
                    dec.win = WIN_NONE;
                end
            endcase
        end
    end
endmodule

// File: rtl/dma_chan_core.sv
module dma_chan_core
    import dma_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  logic              tc_clr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [CNT_W-1:0]  cur_cnt,
    output logic [DATA_W-1:0] misc,
    output logic              tc,
    output logic              step_go
);
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  base_cnt;
    logic              wrap;

    assign step_go = step && misc[0] && !wr_en;
    assign wrap    = step_go && (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            cur_addr  <= '0;
            base_cnt  <= '0;
            cur_cnt   <= '0;
            misc      <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < ADDR_BYTES; b++) begin
                if (wr_idx == IDX_W'(b)) begin
                    base_addr[DATA_W*b +: DATA_W] <= wdata;
                    cur_addr[DATA_W*b +: DATA_W]  <= wdata;
                end
            end
            for (int b = 0; b < CNT_BYTES; b++) begin
                if (wr_idx == IDX_W'(ADDR_BYTES + b)) begin
                    base_cnt[DATA_W*b +: DATA_W] <= wdata;
                    cur_cnt[DATA_W*b +: DATA_W]  <= wdata;
                end
            end
            if (wr_idx == IDX_W'(IDX_MISC)) misc <= wdata;
        end else if (step_go) begin
            if (wrap) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + ADDR_W'(1);
                cur_cnt  <= cur_cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         tc <= 1'b0;
        else if (wrap)   tc <= 1'b1;
        else if (tc_clr) tc <= 1'b0;
    end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int CHAN = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    input  logic [IO_AW-1:0]  slave_base,
    input  logic [IO_AW-1:0]  audio_base,
    input  logic              snoop_en,
    input  logic              xfer_step,
    output logic              io_ack,
    output logic [DATA_W-1:0] io_rdata,
    output logic              tc_flag
);
    dec_t              dec;
    logic              byte_ptr;
    logic              rd_ok, wr_en, tc_clr, step_go;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [DATA_W-1:0] misc;
    logic [CAT_W-1:0]  cat;
    logic [DATA_W-1:0] rd_val;

    dma_io_decode u_dec (
        .addr(io_addr), .slave_base(slave_base), .audio_base(audio_base),
        .byte_ptr(byte_ptr), .dec(dec)
    );

    assign rd_ok  = io_rd && dec.hit && (dec.win != WIN_LEGACY || snoop_en);
    assign wr_en  = io_wr && dec.hit && (dec.idx != IDX_W'(IDX_STAT));
    assign tc_clr = rd_ok && dec.win == WIN_LEGACY && dec.idx == IDX_W'(IDX_STAT);

    dma_chan_core u_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(dec.idx),
        .wdata(io_wdata), .step(xfer_step), .tc_clr(tc_clr),
        .cur_addr(cur_addr), .cur_cnt(cur_cnt), .misc(misc),
        .tc(tc_flag), .step_go(step_go)
    );

    assign cat = {cur_cnt, cur_addr};

    always_comb begin
        rd_val = '0;
        for (int i = 0; i < IDX_MISC; i++)
            if (dec.idx == IDX_W'(i)) rd_val = cat[DATA_W*i +: DATA_W];
        if (dec.idx == IDX_W'(IDX_MISC)) rd_val = misc;
        if (dec.idx == IDX_W'(IDX_STAT))
            rd_val = status_byte(dec.win, tc_flag, misc[0], byte_ptr, CHAN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            io_ack   <= 1'b0;
            io_rdata <= '0;
        end else if (rd_ok) begin
            io_ack   <= 1'b1;
            io_rdata <= rd_val;
        end else begin
            io_ack   <= 1'b0;
            io_rdata <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            byte_ptr <= 1'b0;
        else if (dec.ptr_port && (rd_ok || (io_wr && dec.hit)))
            byte_ptr <= ~byte_ptr;
    end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
    import dma_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              io_rd,
    input logic [IO_AW-1:0]  io_addr,
    input logic [IO_AW-1:0]  slave_base,
    input logic [IO_AW-1:0]  audio_base,
    input logic              snoop_en,
    input logic              io_ack,
    input logic [DATA_W-1:0] io_rdata,
    input logic              tc_flag,
    input logic              step_go,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [CNT_W-1:0]  cur_cnt
);
    // R6
    ack_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
        io_ack |-> $past(io_rd));

    // R6
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !io_ack |-> io_rdata == '0);

    // R5
    snoop_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !snoop_en && io_addr == 16'h0083
         && slave_base[15:4] != 12'h008 && audio_base[15:4] != 12'h008)
        |=> !io_ack);

    // R7
    step_advance_chk: assert property (@(posedge clk) disable iff (rst)
        (step_go && cur_cnt != '0)
        |=> (cur_addr == $past(cur_addr) + 32'd1) && (cur_cnt == $past(cur_cnt) - 24'd1));

    // R8
    wrap_sets_tc_chk: assert property (@(posedge clk) disable iff (rst)
        (step_go && cur_cnt == '0) |=> tc_flag);

    // R8
    tc_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_flag) |-> $past(step_go));
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
    .clk(clk), .rst(rst), .io_rd(io_rd), .io_addr(io_addr),
    .slave_base(slave_base), .audio_base(audio_base), .snoop_en(snoop_en),
    .io_ack(io_ack), .io_rdata(io_rdata), .tc_flag(tc_flag),
    .step_go(step_go), .cur_addr(cur_addr), .cur_cnt(cur_cnt)
);

// File: tb/sim_dma_chan_regs.sv
module sim_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [15:0] slave_base = 16'h0100;
    logic [15:0] audio_base = 16'h0200;
    logic        snoop_en = 1'b1;
    logic        xfer_step = 1'b0;
    logic        io_ack;
    logic [7:0]  io_rdata;
    logic        tc_flag;

    localparam logic [15:0] SB = 16'h0100;
    localparam logic [15:0] AB = 16'h0200;

    always #10 clk = ~clk;

    dma_chan_regs #(.CHAN(1)) u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .slave_base(slave_base), .audio_base(audio_base),
        .snoop_en(snoop_en), .xfer_step(xfer_step), .io_ack(io_ack),
        .io_rdata(io_rdata), .tc_flag(tc_flag)
    );

    typedef struct {
        int         due;
        bit         ack;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops each expectation once its cycle has come
    always @(negedge clk) begin
        if (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (io_ack !== e.ack || io_rdata !== e.data) begin
                n_fail++;
                $display("FAIL %s: ack=%0b data=%02h expected ack=%0b data=%02h",
                         e.tag, io_ack, io_rdata, e.ack, e.data);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input bit ack, input logic [7:0] d,
                      input string tag);
        exp_t e;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        e.due = cyc + 1; e.ack = ack; e.data = d; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic step1();
        @(negedge clk);
        xfer_step = 1'b1;
        @(negedge clk);
        xfer_step = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic expv, input string tag);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk_bit(io_ack, 1'b0, "R1 ack in reset");
        rst = 1'b0;
        // R1 reset values
        for (int i = 0; i < 9; i++) rd(SB + 16'(i), 1'b1, 8'h00, "R1 reset value");
        chk_bit(tc_flag, 1'b0, "R1 tc after reset");

        // R2 / R3 writes through slave window, reads through audio window
        wr(SB + 0, 8'h34); wr(SB + 1, 8'h12); wr(SB + 2, 8'h56); wr(SB + 3, 8'h00);
        wr(SB + 4, 8'h02); wr(SB + 5, 8'h00); wr(SB + 6, 8'h00);
        rd(AB + 0, 1'b1, 8'h34, "R2 audio addr0");
        rd(AB + 1, 1'b1, 8'h12, "R2 audio addr1");
        rd(AB + 2, 1'b1, 8'h56, "R2 audio addr2");
        rd(AB + 4, 1'b1, 8'h02, "R2 audio cnt0");

        // R4 fixed ports with byte pointer
        rd(16'h0000, 1'b1, 8'h34, "R4 port0 low");
        rd(16'h0000, 1'b1, 8'h12, "R4 port0 high");
        rd(16'h0087, 1'b1, 8'h56, "R4 page port");
        rd(16'h0001, 1'b1, 8'h02, "R4 count low");
        rd(16'h0003, 1'b1, 8'h00, "R4 count high");

        // R5 snoop gating; refused read leaves pointer
        snoop_en = 1'b0;
        rd(16'h0000, 1'b0, 8'h00, "R5 gated read");
        rd(16'h0083, 1'b0, 8'h00, "R5 gated page");
        snoop_en = 1'b1;
        rd(16'h0000, 1'b1, 8'h34, "R5 pointer kept low");
        rd(16'h0000, 1'b1, 8'h12, "R4 pointer high");
        rd(16'h0300, 1'b0, 8'h00, "R5 undecoded");
        rd(SB + 9, 1'b0, 8'h00, "R2 offset 9 undecoded");

        // R4 / R5 fixed-port writes while snoop off
        snoop_en = 1'b0;
        wr(16'h0002, 8'h78); wr(16'h0002, 8'h9A);
        snoop_en = 1'b1;
        rd(SB + 0, 1'b1, 8'h78, "R4 port write low");
        rd(SB + 1, 1'b1, 8'h9A, "R4 port write high");
        rd(SB + 2, 1'b1, 8'h56, "R4 page untouched");

        // R7 step ignored while disabled
        step1();
        rd(SB + 0, 1'b1, 8'h78, "R7 step without run");
        wr(SB + 7, 8'h01);
        rd(AB + 7, 1'b1, 8'h01, "R2 control readback");
        step1();
        rd(SB + 0, 1'b1, 8'h79, "R7 addr advance");
        rd(SB + 4, 1'b1, 8'h01, "R7 count down");
        step1();
        @(negedge clk);
        chk_bit(tc_flag, 1'b0, "R8 no tc before wrap");
        step1();
        @(negedge clk);
        chk_bit(tc_flag, 1'b1, "R8 tc at wrap");
        rd(SB + 0, 1'b1, 8'h78, "R3 R8 reload addr from base");
        rd(SB + 4, 1'b1, 8'h02, "R3 R8 reload count from base");

        // R9 / R10 status formats and clearing
        rd(SB + 8, 1'b1, 8'h11, "R9 slave status");
        rd(16'h0001, 1'b1, 8'h02, "R4 count low ptr to 1");
        rd(AB + 8, 1'b1, 8'h83, "R9 audio status");
        rd(SB + 8, 1'b1, 8'h11, "R10 slave read keeps tc");
        rd(16'h0008, 1'b1, 8'h22, "R9 port status");
        rd(16'h0008, 1'b1, 8'h20, "R10 tc cleared");
        @(negedge clk);
        chk_bit(tc_flag, 1'b0, "R10 tc flag low");

        // R7 write beats simultaneous step
        @(negedge clk);
        io_addr = SB + 4; io_wdata = 8'h05; io_wr = 1'b1; xfer_step = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; xfer_step = 1'b0;
        rd(SB + 0, 1'b1, 8'h78, "R7 step blocked by write");
        rd(SB + 4, 1'b1, 8'h05, "R7 write wins");

        // R11 status read-only
        wr(SB + 8, 8'hFF);
        rd(SB + 8, 1'b1, 8'h10, "R11 status write ignored");
        rd(SB + 7, 1'b1, 8'h01, "R11 control unchanged");

        // R2 top bytes
        wr(SB + 3, 8'hAB); wr(SB + 6, 8'hCD);
        rd(AB + 3, 1'b1, 8'hAB, "R2 addr byte3");
        rd(AB + 6, 1'b1, 8'hCD, "R2 count byte2");

        repeat (3) @(negedge clk);
        chk_bit(exp_q.size() == 0, 1'b1, "R6 all reads answered");
        finish_run();
    end
endmodule